// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a hardware master for a three-wire serial EEPROM with a separate chip select. A requester places a word address on a parallel input and pulses a request. The block then selects the device and shifts out an 11-bit read command, MSB first. The command is a start bit, a two-bit read opcode and an 8-bit address field. The block then clocks in a 16-bit word and presents it together with a one-cycle completion pulse. It also drives a protect-enable line. That line is released for the whole access and restored when the access ends.

Every pin toward the device comes straight from a flop, so none of them can glitch. The serial data returned by the device passes through a synchronizer chain. The length of each serial clock phase comes from a run-time half-period input, counted in system clocks. The delay between select and the first clock edge uses the same count. The high phase of each data bit is stretched by the synchronizer depth, so the sample always sees the bit the device has just presented.

Top module: `mw_rom_reader`

## Requirements
- R1: Out of reset and whenever idle: chip select low, serial clock high, protect-enable high, data-out low, busy low, done low, data output zero.
- R2: On the rising serial clock edges that follow the start bit while selected, the device sees 11 bits MSB first: 1, 1, 0, then the 8-bit address field (the address zero-extended to 8 bits), MSB first.
- R3: Data-out is low on every rising serial clock edge after the eleventh command bit, and whenever chip select is low.
- R4: The 16 bits the device presents after the rising edges 12 to 27 (counting from the start bit) are returned MSB first on the data output when done pulses.
- R5: Access start: protect-enable and serial clock go low before chip select rises. Chip select rises while the clock is low, and the clock rises exactly one half-period later.
- R6: Access end: the clock falls, then chip select falls with the clock low, then protect-enable rises, then the clock rises. Each step is one half-period after the previous one.
- R7: During the command, every serial clock low and high phase lasts exactly one half-period. During the data phase, the low phase lasts one half-period and the high phase lasts one half-period plus the synchronizer depth.
- R8: A request raised while busy is ignored. It neither changes the command being sent nor starts a further access after the current one completes.
- R9: Done is high for exactly one cycle per access. The data output keeps its value until the next access completes.
- R10: A half-period input of zero behaves as a half-period of one system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Read request, sampled while idle |
| addr_i | input | ADDR_W | Word address to read |
| half_i | input | DIV_W | Serial clock half-period in system clocks (0 acts as 1) |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | 16 | Last word read |
| ee_cs_o | output | 1 | Device chip select |
| ee_sk_o | output | 1 | Device serial clock |
| ee_mosi_o | output | 1 | Serial data toward the device |
| ee_prot_o | output | 1 | Protect-enable line |
| ee_miso_i | input | 1 | Serial data from the device |

## Verification
The bench builds the block with an 8-bit address field, a 4-bit half-period input and a two-stage synchronizer. With these values every address bit, including the top one, is exercised. The half-period can be swept from zero to several cycles at run time, so the one-cycle floor and the stretched data-phase high time can both be measured within a single build. The widest address and a zero half-period are directed cases. A mid-access request is also directed, with a different address, to show that it does not change the command being sent.

// File: rtl/mw_rd_pkg.sv
package mw_rd_pkg;

   localparam int CMD_BITS   = 11;
   localparam int WORD_BITS  = 16;
   localparam int ADDR_FIELD = 8;
   localparam int CNT_W      = 5;
   localparam logic [2:0] RD_OP = 3'b110;

   typedef enum logic [3:0] {
      ST_IDLE, ST_PRE, ST_SEL, ST_SKH,
      ST_CLO, ST_CHI, ST_DLO, ST_DHI,
      ST_ESK, ST_ECS, ST_EPR, ST_ESKH
   } mw_state_e;

   typedef struct packed {
      logic cs;
      logic sk;
      logic mosi;
      logic prot;
   } mw_pins_t;

   // Pin levels held while the sequencer sits in a given state.
   function automatic mw_pins_t pins_for(mw_state_e st, logic bit_i);
      mw_pins_t p;
      case (st)
         ST_PRE:  p = '{cs: 1'b0, sk: 1'b0, mosi: 1'b0,  prot: 1'b0};
         ST_SEL:  p = '{cs: 1'b1, sk: 1'b0, mosi: 1'b0,  prot: 1'b0};
         ST_SKH:  p = '{cs: 1'b1, sk: 1'b1, mosi: 1'b0,  prot: 1'b0};
         ST_CLO:  p = '{cs: 1'b1, sk: 1'b0, mosi: bit_i, prot: 1'b0};
         ST_CHI:  p = '{cs: 1'b1, sk: 1'b1, mosi: bit_i, prot: 1'b0};
         ST_DLO:  p = '{cs: 1'b1, sk: 1'b0, mosi: 1'b0,  prot: 1'b0};
         ST_DHI:  p = '{cs: 1'b1, sk: 1'b1, mosi: 1'b0,  prot: 1'b0};
         ST_ESK:  p = '{cs: 1'b1, sk: 1'b0, mosi: 1'b0,  prot: 1'b0};
         ST_ECS:  p = '{cs: 1'b0, sk: 1'b0, mosi: 1'b0,  prot: 1'b0};
         ST_EPR:  p = '{cs: 1'b0, sk: 1'b0, mosi: 1'b0,  prot: 1'b1};
         default: p = '{cs: 1'b0, sk: 1'b1, mosi: 1'b0,  prot: 1'b1};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
   parameter int CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          restart_i,
   input  logic [CW-1:0] len_i,
   output logic          expire_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               cnt_q <= '0;
      else if (restart_i)        cnt_q <= len_i - CW'(1);
      else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
   end

   assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/mw_sync.sv
module mw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mw_rom_reader.sv
module mw_rom_reader
   import mw_rd_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DIV_W  = 8,
   parameter int SYNC_N = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 req_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [DIV_W-1:0]     half_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [WORD_BITS-1:0] data_o,
   output logic                 ee_cs_o,
   output logic                 ee_sk_o,
   output logic                 ee_mosi_o,
   output logic                 ee_prot_o,
   input  logic                 ee_miso_i
);

   localparam int CW    = DIV_W + 3;
   localparam int PAD_W = ADDR_FIELD - ADDR_W;

   if (ADDR_W < 6 || ADDR_W > ADDR_FIELD) begin : g_bad_addr
      $error("ADDR_W must lie in 6..8");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end
   if (SYNC_N < 2 || SYNC_N > 4) begin : g_bad_sync
      $error("SYNC_N must lie in 2..4");
   end

   logic [ADDR_FIELD-1:0] addr_ext;
   if (PAD_W == 0) begin : g_addr_full
      assign addr_ext = addr_i;
   end else begin : g_addr_pad
      assign addr_ext = {{PAD_W{1'b0}}, addr_i};
   end

   mw_state_e             state_q, state_n;
   logic [CMD_BITS-1:0]   cmd_q, cmd_n;
   logic [CNT_W-1:0]      bcnt_q, bcnt_n;
   logic [WORD_BITS-1:0]  shift_q, shift_n;
   mw_pins_t              pins_q;
   logic                  restart, expire, fin, miso_s;
   logic [CW-1:0]         heff, len;

   assign heff = (half_i == '0) ? CW'(1) : CW'(half_i);

   mw_phase_timer #(.CW(CW)) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .len_i     (len),
      .expire_o  (expire)
   );

   mw_sync #(.STAGES(SYNC_N)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (ee_miso_i),
      .q_o    (miso_s)
   );

   always_comb begin
      state_n = state_q;
      cmd_n   = cmd_q;
      bcnt_n  = bcnt_q;
      shift_n = shift_q;
      restart = 1'b0;
      fin     = 1'b0;
      if (state_q == ST_IDLE) begin
         if (req_i) begin
            state_n = ST_PRE;
            restart = 1'b1;
            cmd_n   = {RD_OP, addr_ext};
            bcnt_n  = '0;
         end
      end else if (expire) begin
         restart = 1'b1;
         case (state_q)
            ST_PRE: state_n = ST_SEL;
            ST_SEL: state_n = ST_SKH;
            ST_SKH: state_n = ST_CLO;
            ST_CLO: state_n = ST_CHI;
            ST_CHI: begin
               cmd_n = {cmd_q[CMD_BITS-2:0], 1'b0};
               if (bcnt_q == CNT_W'(CMD_BITS - 1)) begin
                  state_n = ST_DLO;
                  bcnt_n  = '0;
               end else begin
                  state_n = ST_CLO;
                  bcnt_n  = bcnt_q + CNT_W'(1);
               end
            end
            ST_DLO: state_n = ST_DHI;
            ST_DHI: begin
               shift_n = {shift_q[WORD_BITS-2:0], miso_s};
               if (bcnt_q == CNT_W'(WORD_BITS - 1)) begin
                  state_n = ST_ESK;
                  bcnt_n  = '0;
               end else begin
                  state_n = ST_DLO;
                  bcnt_n  = bcnt_q + CNT_W'(1);
               end
            end
            ST_ESK: state_n = ST_ECS;
            ST_ECS: state_n = ST_EPR;
            ST_EPR: state_n = ST_ESKH;
            default: begin
               state_n = ST_IDLE;
               fin     = 1'b1;
            end
         endcase
      end
      len = (state_n == ST_DHI) ? heff + CW'(SYNC_N) : heff;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cmd_q   <= '0;
         bcnt_q  <= '0;
         shift_q <= '0;
         pins_q  <= pins_for(ST_IDLE, 1'b0);
         done_o  <= 1'b0;
         data_o  <= '0;
      end else begin
         state_q <= state_n;
         cmd_q   <= cmd_n;
         bcnt_q  <= bcnt_n;
         shift_q <= shift_n;
         pins_q  <= pins_for(state_n, cmd_n[CMD_BITS-1]);
         done_o  <= fin;
         if (fin) data_o <= shift_q;
      end
   end

   assign busy_o    = (state_q != ST_IDLE);
   assign ee_cs_o   = pins_q.cs;
   assign ee_sk_o   = pins_q.sk;
   assign ee_mosi_o = pins_q.mosi;
   assign ee_prot_o = pins_q.prot;

endmodule

// File: rtl/mw_rom_reader_chk.sv
module mw_rom_reader_chk (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        busy_o,
   input logic        done_o,
   input logic [15:0] data_o,
   input logic        ee_cs_o,
   input logic        ee_sk_o,
   input logic        ee_mosi_o,
   input logic        ee_prot_o
);

   AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !done_o) |-> (!ee_cs_o && ee_sk_o && ee_prot_o)); // R1

   AST_MOSI_UNSELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ee_cs_o |-> !ee_mosi_o); // R3

   AST_PROT_WHILE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ee_cs_o |-> !ee_prot_o); // R5

   AST_SEL_RISE_SK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ee_cs_o) |-> !ee_sk_o); // R5

   AST_SEL_FALL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ee_cs_o) |-> (!ee_sk_o && !ee_prot_o)); // R6

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R9

   AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(data_o)); // R9

endmodule

bind mw_rom_reader mw_rom_reader_chk u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .data_o    (data_o),
   .ee_cs_o   (ee_cs_o),
   .ee_sk_o   (ee_sk_o),
   .ee_mosi_o (ee_mosi_o),
   .ee_prot_o (ee_prot_o)
);

// File: tb/mw_rom_reader_bench.sv
module mw_rom_reader_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [7:0]  addr = '0;
   logic [3:0]  half = 4'd1;
   logic        busy, done;
   logic [15:0] data;
   logic        ee_cs, ee_sk, ee_mosi, ee_prot;
   logic        ee_miso = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   logic [15:0] resp_word = '0;
   logic [15:0] prev_word = '0;

   always #5 clk = ~clk;

   mw_rom_reader #(.ADDR_W(8), .DIV_W(4), .SYNC_N(2)) u_mw_rom_reader (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .half_i(half),
      .busy_o(busy), .done_o(done), .data_o(data),
      .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_mosi_o(ee_mosi), .ee_prot_o(ee_prot),
      .ee_miso_i(ee_miso)
   );

   // Behavioural device: waits for the start bit, counts edges, then shifts out the word.
   int  r_cnt = 0;
   bit  r_started = 0;
   always @(posedge ee_sk or negedge ee_cs) begin
      if (!ee_cs) begin
         r_started = 0;
         r_cnt = 0;
         ee_miso <= 1'b0;
      end else if (!r_started) begin
         if (ee_mosi) begin
            r_started = 1;
            r_cnt = 1;
         end
      end else begin
         r_cnt++;
         if (r_cnt >= 12 && r_cnt <= 27) ee_miso <= resp_word[27 - r_cnt];
         else                            ee_miso <= 1'b0;
      end
   end

   function automatic int half_eff(input int h);
      return (h == 0) ? 1 : h;
   endfunction

   function automatic logic [10:0] exp_cmd(input logic [7:0] a);
      return {3'b110, a};
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp_v);
      end
   endtask

   task automatic run_read(input logic [7:0] a, input logic [15:0] w, input int h, input bit poke);
      int heff, cyc, lowrun, highrun, ne, cs_rise_c, cs_fall_c, pr_rise_c;
      bit p_sk, p_cs, p_prot, started, got_done, wait_skh, wait_last;
      logic [10:0] cmd;
      string rq_t;
      heff = half_eff(h);
      rq_t = (h == 0) ? "R10" : "R7";
      resp_word = w;
      half = 4'(h);
      @(negedge clk);
      addr = a;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      p_sk = 1; p_cs = 0; p_prot = 1;
      lowrun = 0; highrun = 0; ne = 0; started = 0; got_done = 0;
      wait_skh = 0; wait_last = 0; cmd = '0;
      cs_rise_c = 0; cs_fall_c = 0; pr_rise_c = 0;
      for (cyc = 0; cyc < 3000 && !got_done; cyc++) begin
         if (poke && cyc == 4) begin addr = ~a; req = 1'b1; end
         else req = 1'b0;
         if (ee_sk && !p_sk) begin
            if (ee_cs) begin
               if (wait_skh) begin
                  chk(cyc - cs_rise_c == heff, "R5", cyc - cs_rise_c, heff);
                  wait_skh = 0;
               end
               if (!started && ee_mosi) started = 1;
               if (started) begin
                  ne++;
                  chk(lowrun == heff, rq_t, lowrun, heff);
                  if (ne <= 11) cmd = {cmd[9:0], ee_mosi};
                  else chk(ee_mosi == 1'b0, "R3", ee_mosi, 0);
               end
            end else if (wait_last) begin
               chk(cyc - pr_rise_c == heff, "R6", cyc - pr_rise_c, heff);
               wait_last = 0;
            end
            lowrun = 0; highrun = 1;
         end else if (!ee_sk && p_sk) begin
            if (ee_cs && ne >= 1)
               chk(highrun == ((ne >= 12) ? heff + 2 : heff), rq_t, highrun,
                   (ne >= 12) ? heff + 2 : heff);
            highrun = 0; lowrun = 1;
         end else if (ee_sk) highrun++;
         else lowrun++;
         if (ee_cs && !p_cs) begin
            chk(!ee_prot && !ee_sk, "R5", {ee_prot, ee_sk}, 0);
            chk(data == prev_word, "R9", data, prev_word);
            cs_rise_c = cyc; wait_skh = 1;
         end
         if (!ee_cs && p_cs) begin
            chk(!ee_sk && !ee_prot, "R6", {ee_sk, ee_prot}, 0);
            cs_fall_c = cyc;
         end
         if (ee_prot && !p_prot) begin
            chk(!ee_cs && (cyc - cs_fall_c == heff), "R6", cyc - cs_fall_c, heff);
            pr_rise_c = cyc; wait_last = 1;
         end
         if (done) begin
            got_done = 1;
            chk(data == w, "R4", data, w);
            chk(ne == 27, "R4", ne, 27);
            chk(cmd == exp_cmd(a), "R2", cmd, exp_cmd(a));
            chk(!busy && !ee_cs, "R1", {busy, ee_cs}, 0);
         end
         p_sk = ee_sk; p_cs = ee_cs; p_prot = ee_prot;
         if (!got_done) @(negedge clk);
      end
      req = 1'b0;
      if (!got_done) chk(0, "R4", 0, 1);
      @(negedge clk);
      chk(done == 1'b0, "R9", done, 0);
      if (poke) begin
         repeat (6) @(negedge clk);
         chk(!busy && !ee_cs, "R8", {busy, ee_cs}, 0);
      end
      prev_word = w;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL R4 watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1D5E_0C4B));
      repeat (3) @(negedge clk);
      chk(!ee_cs && ee_sk && ee_prot && !ee_mosi, "R1",
          {ee_cs, ee_sk, ee_prot, ee_mosi}, 4'b0110);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy && !done && data == 16'h0, "R1", {busy, done, data}, 0);
      chk(!ee_cs && ee_sk && ee_prot && !ee_mosi, "R1",
          {ee_cs, ee_sk, ee_prot, ee_mosi}, 4'b0110);

      run_read(8'h00, 16'h0000, 1, 0);
      run_read(8'hFF, 16'hFFFF, 2, 0);
      run_read(8'hA5, 16'h8001, 0, 0);   // R10 zero half-period
      run_read(8'h3C, 16'h5AA5, 3, 1);   // R8 request while busy
      run_read(8'h80, 16'h7FFE, 1, 0);
      for (int i = 0; i < 16; i++)
         run_read(8'($urandom), 16'($urandom), int'($urandom_range(0, 5)), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule